// File: doc/BRIEF.md
# Mirrored Power Rail Sequencer

This block switches the enables of four supply rails and the release of an active-low system reset, in a timed order, whenever the chip powers up or down. A one-millisecond tick input paces everything. A single 6-bit millisecond counter counts up during power-up. During power-down it counts back down from its top value of 63. Each rail turns on when the counter reaches that rail's on-threshold. Because the count runs backwards on the way down, each rail turns off after 63 minus its on-delay, so the power-down order is the exact reverse of the power-up order and needs no second table.

Two delay profiles are built in. The standard profile staggers the rails. The alternate profile brings all four rails up together late in the frame and drops them early on the way down. The profile input is sampled once, when a power-up begins, and that choice governs the whole up-and-down cycle that follows. A shut-down command that arrives part way through power-up reverses the counter from where it stands, so only the rails already enabled are dropped, in reverse order. A one-cycle done pulse marks the end of each sequence.

Top module: `rail_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released, every `rail_en` bit is 0, `sys_rst_n` is 0 and `seq_done` is 0, and the block waits in the powered-off state. Asserting `rst_n` low in the middle of a sequence returns the block to that state.
- R2: A `start_up` pulse in the powered-off state starts power-up with the counter at 0. Each `tick_1ms` pulse adds one, and nothing else moves it. Under the standard profile, a rail turns on once the tick count reaches its on-delay. The rail bits are `rail_en[0]` for the LDO pair (5), `rail_en[1]` for the first buck (15), `rail_en[2]` for the second buck (20) and `rail_en[3]` for the buck-boost (25).
- R3: `sys_rst_n` goes high only once the power-up count has reached 60 ticks and all four rails are enabled. It is low whenever any rail is disabled.
- R4: `seq_done` is high for exactly one cycle, in the clock cycle after the 63rd tick of a power-up or of a power-down. After power-up completes, all rails and the reset release stay on through any number of ticks.
- R5: A `shut_down` pulse after power-up completes starts power-down. Under the standard profile, measured in ticks from that pulse: `sys_rst_n` falls after 3, then the buck-boost turns off after 38, the second buck after 43, the first buck after 48 and the LDO pair after 58.
- R6: Under the alternate profile, selected by `alt_profile`=1, all four rails turn on at 53 ticks and the reset releases at 60. On power-down, the reset falls after 3 ticks and all four rails turn off after 10.
- R7: `alt_profile` is captured only on the cycle a power-up is accepted. Changes to it at any other time have no effect on the current up and down sequence.
- R8: A `shut_down` pulse during power-up aborts it. The counter then counts down from its current value, and each enabled rail turns off once the counter has fallen to that rail's on-delay. From a count of 22, the second buck drops after 2 ticks, the first buck after 7 and the LDO pair after 17, and done pulses after 22 ticks.
- R9: `start_up` is ignored unless the block is powered off, and `shut_down` is ignored while powered off. If both arrive together in the powered-off state, power-up starts.
- R10: Under the standard profile, a rail with a higher index is never enabled while a rail with a lower index is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| start_up | input | 1 | One-cycle power-up command |
| shut_down | input | 1 | One-cycle power-down command |
| alt_profile | input | 1 | 0 = standard delays, 1 = alternate delays; sampled at power-up start |
| rail_en | output | 4 | Rail enables: [0] LDO pair, [1] first buck, [2] second buck, [3] buck-boost |
| sys_rst_n | output | 1 | Active-low system reset, high when released |
| seq_done | output | 1 | One-cycle pulse at the end of each sequence |

## Verification
The assertions assume that `tick_1ms` is a single-cycle pulse and that `start_up` and `shut_down` are also single-cycle pulses that never share a cycle with a tick, so each counter step comes from exactly one cause. The stimulus drives every command as an isolated pulse on a falling edge and issues ticks only afterwards. The profile input is changed only in cycles where a correct design must ignore it. The rail-nesting check relies on the default standard thresholds being in ascending order across the rail index.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_UP   = 2'd1,
    PH_ON   = 2'd2,
    PH_DOWN = 2'd3
  } phase_e;

endpackage

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_up,
  input  logic   shut_down,
  input  logic   cnt_at_max,
  input  logic   cnt_at_zero,
  output phase_e phase,
  output logic   launch,
  output logic   seq_done
);

  phase_e ph_nxt;
  logic   done_nxt;

  // a new run is accepted only from the powered-off state
  assign launch = (phase == PH_OFF) && start_up;

  always_comb begin
    ph_nxt   = phase;
    done_nxt = 1'b0;
    case (phase)
      PH_OFF:  if (start_up) ph_nxt = PH_UP;
      PH_UP: begin
        if (shut_down) begin
          ph_nxt = PH_DOWN;
        end else if (cnt_at_max) begin
          ph_nxt   = PH_ON;
          done_nxt = 1'b1;
        end
      end
      PH_ON:   if (shut_down) ph_nxt = PH_DOWN;
      PH_DOWN: begin
        if (cnt_at_zero) begin
          ph_nxt   = PH_OFF;
          done_nxt = 1'b1;
        end
      end
      default: ph_nxt = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OFF;
      seq_done <= 1'b0;
    end else begin
      phase    <= ph_nxt;
      seq_done <= done_nxt;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) seq_done |=> !seq_done); // R4
  AST_START_IGNORED_ON: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_ON && !shut_down) |=> phase == PH_ON); // R9
  AST_OFF_LEAVES_TO_UP: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_OFF && !start_up) |=> phase == PH_OFF); // R9

endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer
  import rail_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic             launch,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max,
  output logic             at_zero
);

  localparam logic [CNT_W-1:0] TOP = '1;

  assign at_max  = (cnt == TOP);
  assign at_zero = (cnt == '0);

  // one counter serves both directions: up while powering up, down while
  // powering down, frozen otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (launch) begin
      cnt <= '0;
    end else if (tick) begin
      if (phase == PH_UP && !at_max)
        cnt <= cnt + 1'b1;
      else if (phase == PH_DOWN && !at_zero)
        cnt <= cnt - 1'b1;
    end
  end

  AST_CNT_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_UP && tick && !launch && cnt != TOP) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_DOWN && tick && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!tick && !launch) |=> $stable(cnt)); // R2

endmodule

// File: rtl/rail_seq_decode.sv
module rail_seq_decode
  import rail_seq_pkg::*;
#(
  parameter int                          CNT_W       = 6,
  parameter int                          NUM_RAILS   = 4,
  parameter logic [NUM_RAILS*CNT_W-1:0]  STD_OFF_MS  = {6'd38, 6'd43, 6'd48, 6'd58},
  parameter logic [NUM_RAILS*CNT_W-1:0]  ALT_OFF_MS  = {6'd10, 6'd10, 6'd10, 6'd10},
  parameter logic [CNT_W-1:0]            STD_RST_OFF = 6'd3,
  parameter logic [CNT_W-1:0]            ALT_RST_OFF = 6'd3
) (
  input  phase_e               phase,
  input  logic [CNT_W-1:0]     cnt,
  input  logic                 alt_q,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 sys_rst_n
);

  // frame length is the counter's top value; on-delays mirror off-delays
  localparam logic [CNT_W-1:0] FRAME      = '1;
  localparam logic [CNT_W-1:0] STD_RST_ON = FRAME - STD_RST_OFF;
  localparam logic [CNT_W-1:0] ALT_RST_ON = FRAME - ALT_RST_OFF;

  logic [CNT_W-1:0] rst_thr;
  logic             rst_rel;

  for (genvar k = 0; k < NUM_RAILS; k++) begin : g_rail
    localparam logic [CNT_W-1:0] STD_ON = FRAME - STD_OFF_MS[k*CNT_W +: CNT_W];
    localparam logic [CNT_W-1:0] ALT_ON = FRAME - ALT_OFF_MS[k*CNT_W +: CNT_W];
    logic [CNT_W-1:0] thr;
    assign thr = alt_q ? ALT_ON : STD_ON;
    // rising count: on at the threshold; falling count: off at the threshold
    assign rail_en[k] = (phase == PH_ON)
                      | ((phase == PH_UP)   && (cnt >= thr))
                      | ((phase == PH_DOWN) && (cnt >  thr));
  end

  assign rst_thr   = alt_q ? ALT_RST_ON : STD_RST_ON;
  assign rst_rel   = (phase == PH_ON)
                   | ((phase == PH_UP)   && (cnt >= rst_thr))
                   | ((phase == PH_DOWN) && (cnt >  rst_thr));
  assign sys_rst_n = rst_rel && (&rail_en);

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int                          CNT_W       = 6,
  parameter int                          NUM_RAILS   = 4,
  parameter logic [NUM_RAILS*CNT_W-1:0]  STD_OFF_MS  = {6'd38, 6'd43, 6'd48, 6'd58},
  parameter logic [NUM_RAILS*CNT_W-1:0]  ALT_OFF_MS  = {6'd10, 6'd10, 6'd10, 6'd10},
  parameter logic [CNT_W-1:0]            STD_RST_OFF = 6'd3,
  parameter logic [CNT_W-1:0]            ALT_RST_OFF = 6'd3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_1ms,
  input  logic                 start_up,
  input  logic                 shut_down,
  input  logic                 alt_profile,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 sys_rst_n,
  output logic                 seq_done
);

  phase_e           phase;
  logic             launch;
  logic [CNT_W-1:0] cnt;
  logic             at_max;
  logic             at_zero;
  logic             alt_q;

  // profile is frozen for the whole up/down cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alt_q <= 1'b0;
    else if (launch) alt_q <= alt_profile;
  end

  rail_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_up    (start_up),
    .shut_down   (shut_down),
    .cnt_at_max  (at_max),
    .cnt_at_zero (at_zero),
    .phase       (phase),
    .launch      (launch),
    .seq_done    (seq_done)
  );

  rail_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .launch  (launch),
    .tick    (tick_1ms),
    .cnt     (cnt),
    .at_max  (at_max),
    .at_zero (at_zero)
  );

  rail_seq_decode #(
    .CNT_W       (CNT_W),
    .NUM_RAILS   (NUM_RAILS),
    .STD_OFF_MS  (STD_OFF_MS),
    .ALT_OFF_MS  (ALT_OFF_MS),
    .STD_RST_OFF (STD_RST_OFF),
    .ALT_RST_OFF (ALT_RST_OFF)
  ) u_decode (
    .phase     (phase),
    .cnt       (cnt),
    .alt_q     (alt_q),
    .rail_en   (rail_en),
    .sys_rst_n (sys_rst_n)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_OFF) |-> (rail_en == '0 && !sys_rst_n)); // R1
  AST_UP_ONLY_RISES: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_UP && $past(phase) == PH_UP) |-> ((rail_en & $past(rail_en)) == $past(rail_en))); // R2
  AST_DOWN_ONLY_FALLS: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_DOWN && $past(phase) == PH_DOWN) |-> ((rail_en | $past(rail_en)) == $past(rail_en))); // R5
  AST_ON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_ON) |-> (&rail_en && sys_rst_n)); // R4

  for (genvar k = 1; k < NUM_RAILS; k++) begin : g_nest
    AST_STD_NESTED: assert property (@(posedge clk) disable iff (!rst_n) (!alt_q && rail_en[k]) |-> rail_en[k-1]); // R10
  end

endmodule

// File: tb/tb_rail_sequencer.sv
`timescale 1ns/100ps
module tb_rail_sequencer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1ms;
  logic       start_up;
  logic       shut_down;
  logic       alt_profile;
  logic [3:0] rail_en;
  logic       sys_rst_n;
  logic       seq_done;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ended  = 1'b0;

  always #2.5 clk = ~clk;

  rail_sequencer dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1ms    (tick_1ms),
    .start_up    (start_up),
    .shut_down   (shut_down),
    .alt_profile (alt_profile),
    .rail_en     (rail_en),
    .sys_rst_n   (sys_rst_n),
    .seq_done    (seq_done)
  );

  // vector = {op[1:0], ticks[7:0], rail_en[3:0], sys_rst_n, seq_done}
  localparam logic [1:0] OP_TICK  = 2'd0;
  localparam logic [1:0] OP_START = 2'd1;
  localparam logic [1:0] OP_SHUT  = 2'd2;
  localparam logic [1:0] OP_IDLE  = 2'd3;
  localparam int NV = 25;
  localparam logic [15:0] VEC [NV] = '{
    {OP_START, 8'd4,  4'b0000, 1'b0, 1'b0},  // R2 count 4
    {OP_TICK,  8'd1,  4'b0001, 1'b0, 1'b0},  // R2 LDO at 5
    {OP_TICK,  8'd9,  4'b0001, 1'b0, 1'b0},  // 14
    {OP_TICK,  8'd1,  4'b0011, 1'b0, 1'b0},  // buck1 at 15
    {OP_TICK,  8'd5,  4'b0111, 1'b0, 1'b0},  // buck2 at 20
    {OP_TICK,  8'd4,  4'b0111, 1'b0, 1'b0},  // 24
    {OP_TICK,  8'd1,  4'b1111, 1'b0, 1'b0},  // buck-boost at 25
    {OP_TICK,  8'd34, 4'b1111, 1'b0, 1'b0},  // R3 59
    {OP_TICK,  8'd1,  4'b1111, 1'b1, 1'b0},  // R3 release at 60
    {OP_TICK,  8'd3,  4'b1111, 1'b1, 1'b0},  // 63
    {OP_IDLE,  8'd0,  4'b1111, 1'b1, 1'b1},  // R4 done
    {OP_IDLE,  8'd0,  4'b1111, 1'b1, 1'b0},  // R4 single cycle
    {OP_START, 8'd5,  4'b1111, 1'b1, 1'b0},  // R9 start ignored, R4 stays on
    {OP_SHUT,  8'd2,  4'b1111, 1'b1, 1'b0},  // R5 2 ticks down
    {OP_TICK,  8'd1,  4'b1111, 1'b0, 1'b0},  // R5 reset at 3
    {OP_TICK,  8'd34, 4'b1111, 1'b0, 1'b0},  // 37
    {OP_TICK,  8'd1,  4'b0111, 1'b0, 1'b0},  // buck-boost off 38
    {OP_TICK,  8'd4,  4'b0111, 1'b0, 1'b0},  // 42
    {OP_TICK,  8'd1,  4'b0011, 1'b0, 1'b0},  // buck2 off 43
    {OP_TICK,  8'd5,  4'b0001, 1'b0, 1'b0},  // buck1 off 48
    {OP_TICK,  8'd9,  4'b0001, 1'b0, 1'b0},  // 57
    {OP_TICK,  8'd1,  4'b0000, 1'b0, 1'b0},  // LDO off 58
    {OP_TICK,  8'd5,  4'b0000, 1'b0, 1'b0},  // 63
    {OP_IDLE,  8'd0,  4'b0000, 1'b0, 1'b1},  // R4 done after power-down
    {OP_IDLE,  8'd0,  4'b0000, 1'b0, 1'b0}
  };

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic pulse(input logic go_up, input logic go_down);
    start_up  = go_up;
    shut_down = go_down;
    @(negedge clk);
    start_up  = 1'b0;
    shut_down = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1ms = 1'b1;
      @(negedge clk);
      tick_1ms = 1'b0;
    end
  endtask

  task automatic expect_out(input string req, input logic [3:0] en,
                            input logic rn, input logic dn);
    n_chk++;
    if (rail_en !== en || sys_rst_n !== rn || seq_done !== dn) begin
      n_fail++;
      $display("FAIL %s: rail_en=%b sys_rst_n=%b seq_done=%b expected %b %b %b",
               req, rail_en, sys_rst_n, seq_done, en, rn, dn);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; tick_1ms = 1'b0; start_up = 1'b0; shut_down = 1'b0; alt_profile = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 after reset", 4'b0000, 1'b0, 1'b0);

    // R9: shut_down while off has no effect
    pulse(1'b0, 1'b1);
    ticks(30);
    expect_out("R9 shut while off", 4'b0000, 1'b0, 1'b0);

    // standard cycle from the table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][15:14])
        OP_START: begin pulse(1'b1, 1'b0); alt_profile = 1'b1; end  // R7: late change ignored
        OP_SHUT:  pulse(1'b0, 1'b1);
        OP_IDLE:  @(negedge clk);
        default:  ;
      endcase
      ticks(int'(VEC[i][13:6]));
      expect_out($sformatf("R2/R3/R4/R5/R7 vector %0d", i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // R6 alternate profile; R7 clearing the input mid-run keeps it
    alt_profile = 1'b1;
    pulse(1'b1, 1'b0);
    alt_profile = 1'b0;
    ticks(52);
    expect_out("R6 alt up 52", 4'b0000, 1'b0, 1'b0);
    ticks(1);
    expect_out("R6 alt up 53", 4'b1111, 1'b0, 1'b0);
    ticks(6);
    expect_out("R6 alt up 59", 4'b1111, 1'b0, 1'b0);
    ticks(1);
    expect_out("R6 alt reset 60", 4'b1111, 1'b1, 1'b0);
    ticks(3);
    @(negedge clk);
    expect_out("R6 alt up done", 4'b1111, 1'b1, 1'b1);
    pulse(1'b0, 1'b1);
    ticks(2);
    expect_out("R7 alt down 2", 4'b1111, 1'b1, 1'b0);
    ticks(1);
    expect_out("R6 alt reset at 3", 4'b1111, 1'b0, 1'b0);
    ticks(6);
    expect_out("R7 alt down 9", 4'b1111, 1'b0, 1'b0);
    ticks(1);
    expect_out("R6 alt rails off 10", 4'b0000, 1'b0, 1'b0);
    ticks(53);
    @(negedge clk);
    expect_out("R6 alt down done", 4'b0000, 1'b0, 1'b1);

    // R8 abort at count 22
    @(negedge clk);
    pulse(1'b1, 1'b0);
    ticks(22);
    expect_out("R8 before abort", 4'b0111, 1'b0, 1'b0);
    pulse(1'b0, 1'b1);
    ticks(1);
    expect_out("R8 abort 1", 4'b0111, 1'b0, 1'b0);
    ticks(1);
    expect_out("R8 buck2 off", 4'b0011, 1'b0, 1'b0);
    ticks(5);
    expect_out("R8 buck1 off", 4'b0001, 1'b0, 1'b0);
    ticks(10);
    expect_out("R8 LDO off", 4'b0000, 1'b0, 1'b0);
    ticks(5);
    @(negedge clk);
    expect_out("R8 abort done", 4'b0000, 1'b0, 1'b1);
    @(negedge clk);
    expect_out("R8 done single", 4'b0000, 1'b0, 1'b0);

    // R9 both commands while off: power-up wins
    pulse(1'b1, 1'b1);
    ticks(5);
    expect_out("R9 simultaneous start", 4'b0001, 1'b0, 1'b0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    expect_out("R1 reset mid-run", 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;
    ticks(10);
    expect_out("R1 stays off after reset", 4'b0000, 1'b0, 1'b0);

    summary();
  end

endmodule